// File: doc/BRIEF.md
# CPU Halt and Wake Controller

This block holds a small processor in its low-power halt state and brings it back out. A one-cycle strobe from the instruction decoder parks the core by dropping its clock enable. The controller then watches the per-source interrupt requests, each qualified by its own enable bit. When any qualified request appears, it restores the clock enable and emits a wake pulse. It then waits for the core to report one finished instruction (the one stored right after the halt instruction) before it signals the interrupt controller to start entry. The routine therefore returns to the instruction two places after the halt.

The same block combines the conditions that force a system reset. These are a reset pin held high for a programmable number of low-speed ticks, every key of a key group held down together for another tick count, and, when a configuration input allows it, a low-speed oscillator that has stopped toggling. A reset request clears the halt state. In any cycle where it coincides with a wake-up, the reset request wins.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While and after the synchronous active-low reset, cpu_clk_en is 1 and wake_pulse, take_irq and sys_reset are 0.
- R2: A halt_strobe sampled while running, with no reset request present, drops cpu_clk_en at the next edge. It stays 0 until a wake-up or a reset request.
- R3: While halted, a request on line i with irq_en[i]=1 raises cpu_clk_en and a one-cycle wake_pulse at the next edge. A request whose enable bit is 0 leaves the core halted.
- R4: master_ie has no influence on whether a qualified request wakes the core.
- R5: After a wake-up, take_irq stays 0 until the first instr_done handshake. It pulses for one cycle at the edge after that handshake if master_ie was 1 at the handshake, and stays 0 if master_ie was 0.
- R6: rst_pin held high for RST_TICKS low-speed ticks (one tick every TICK_DIV clock cycles) raises sys_reset. Any low sample restarts the count, and sys_reset falls within two cycles of release.
- R7: All KEY_W bits of key_in at 1 (1 means pressed) for KEY_TICKS ticks raise sys_reset. Any key reading 0 restarts the count.
- R8: With osc_chk_en=1, if lsclk shows no rising edge for OSC_TIMEOUT cycles, sys_reset rises. Allowing for a two-stage input synchronizer, it rises exactly OSC_TIMEOUT+4 edges after lsclk was driven high for the last time. With osc_chk_en=0 a stopped lsclk never raises sys_reset.
- R9: A reset request clears the halt state. If it is present at an edge, that edge yields cpu_clk_en=1, no wake_pulse and no take_irq, even when a qualified request or handshake arrives at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_strobe | input | 1 | One-cycle pulse from the decoder for a halt instruction |
| irq_req | input | NUM_IRQ | Per-source interrupt request levels |
| irq_en | input | NUM_IRQ | Per-source enable bits |
| master_ie | input | 1 | Global interrupt enable, used only to decide interrupt entry |
| instr_done | input | 1 | Core reports one instruction completed |
| rst_pin | input | 1 | External reset pin, active high |
| key_in | input | KEY_W | Key group levels, 1 = pressed |
| lsclk | input | 1 | Low-speed oscillator output, asynchronous |
| osc_chk_en | input | 1 | Configuration bit enabling stopped-oscillator reset |
| cpu_clk_en | output | 1 | Clock enable for the core, 0 while halted |
| wake_pulse | output | 1 | One-cycle pulse on interrupt wake-up |
| take_irq | output | 1 | One-cycle pulse telling the core to enter the interrupt routine |
| sys_reset | output | 1 | System reset request, registered |

## Verification
Wake-up and the stopped-oscillator reset can fall on the same clock edge. Ties between the tick-driven filters and the core handshakes depend on tick phase. The oscillator path, however, has a fixed latency from the last lsclk rise. The bench uses it to time a qualified interrupt request so that it arrives at exactly the edge where the reset request first appears. It then judges the result one cycle later: sys_reset is high, the clock enable is back, and neither wake_pulse nor take_irq appears in that cycle or the next.

// File: rtl/halt_wake_pkg.sv
// Package: shared types of the halt/wake controller.
// Assumes: nothing beyond IEEE 1800-2017.
package halt_wake_pkg;

    // Sequencer states: running, parked, and resuming (one instruction pending)
    typedef enum logic [1:0] {
        HS_RUN    = 2'd0,
        HS_HALT   = 2'd1,
        HS_RESUME = 2'd2
    } hstate_e;

endpackage

// File: rtl/hw_tick_gen.sv
// Module: hw_tick_gen
// Divides the system clock into a one-cycle tick every DIV cycles; the
// tick times the long-hold filters.
// Assumes: DIV >= 2; tick phase is free running from reset.
module hw_tick_gen #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divider counter, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // Tick never lasts longer than one cycle (supports R6, R7 timing)
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/hw_hold_filter.sv
// Module: hw_hold_filter
// Reports that a condition has stayed true for THRESH ticks. Any cycle
// with the condition false clears the count at once.
// Assumes: cond is already synchronous to clk.
module hw_hold_filter #(
    parameter int THRESH = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] TOP = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    // Count ticks while cond holds, saturate at THRESH, restart on release
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!cond)               cnt_q <= '0;
        else if (tick && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == TOP);

    // R6/R7: a release always restarts the measurement
    p_release_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt_q == '0));
    // R6/R7: a hit implies the condition was present at the previous edge
    p_hit_needs_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(cond));
endmodule

// File: rtl/hw_osc_watch.sv
// Module: hw_osc_watch
// Synchronises the low-speed clock, detects its rising edges and flags a
// stall when TIMEOUT system cycles pass without one.
// Assumes: lsclk is asynchronous and much slower than clk.
module hw_osc_watch #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lsclk,
    output logic stalled
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] TOP = CW'(TIMEOUT);

    logic       s1_q, s2_q, s3_q;
    logic       rise;
    logic [CW-1:0] gap_q;

    // Two-stage synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= lsclk;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;

    // Cycles since the last rising edge, saturating at TIMEOUT
    always_ff @(posedge clk) begin
        if (!rst_n)            gap_q <= '0;
        else if (rise)         gap_q <= '0;
        else if (gap_q != TOP) gap_q <= gap_q + 1'b1;
    end

    assign stalled = (gap_q == TOP);

    // R8: a detected edge always withdraws the stall indication
    p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !stalled);
endmodule

// File: rtl/hw_halt_seq.sv
// Module: hw_halt_seq
// Holds the halt flag and sequences the resume: a qualified request wakes
// the core, one instruction completes, then interrupt entry is signalled.
// Assumes: requests are levels held by their sources; force_clr is the
// combined reset request and overrides everything else.
module hw_halt_seq
    import halt_wake_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_strobe,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               master_ie,
    input  logic               instr_done,
    input  logic               force_clr,
    output logic               cpu_clk_en,
    output logic               wake_pulse,
    output logic               take_irq
);
    hstate_e state_q;
    logic    wake_hit;

    // Only individually enabled sources may end the halt; master_ie is not used here
    assign wake_hit = |(irq_req & irq_en);

    // Halt/resume state machine with registered one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= HS_RUN;
            wake_pulse <= 1'b0;
            take_irq   <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            take_irq   <= 1'b0;
            if (force_clr) begin
                state_q <= HS_RUN;
            end else begin
                case (state_q)
                    HS_RUN: begin
                        if (halt_strobe) state_q <= HS_HALT;
                    end
                    HS_HALT: begin
                        if (wake_hit) begin
                            state_q    <= HS_RESUME;
                            wake_pulse <= 1'b1;
                        end
                    end
                    HS_RESUME: begin
                        if (instr_done) begin
                            state_q  <= HS_RUN;
                            take_irq <= master_ie;
                        end
                    end
                    default: state_q <= HS_RUN;
                endcase
            end
        end
    end

    assign cpu_clk_en = (state_q != HS_HALT);

    // R2: a halt request while running stops the core clock
    p_halt_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RUN && halt_strobe && !force_clr) |=> !cpu_clk_en);
    // R2/R3: without a qualified request or reset the core stays parked
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && !wake_hit && !force_clr) |=> !cpu_clk_en);
    // R3/R4: a qualified request wakes the core whatever master_ie is
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && wake_hit && !force_clr) |=> (cpu_clk_en && wake_pulse && !take_irq));
    // R3: the wake pulse lasts one cycle
    p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    // R5: interrupt entry only follows a handshake with master_ie set
    p_take_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(instr_done) && $past(master_ie)));
    // R9: reset request overrides wake-up and interrupt entry
    p_reset_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (cpu_clk_en && !wake_pulse && !take_irq));
endmodule

// File: rtl/halt_wake_ctrl.sv
// Module: halt_wake_ctrl (top)
// Combines the halt/resume sequencer with the three reset-request sources
// (long pin hold, full key-group hold, stopped low-speed oscillator).
// Assumes: rst_pin and key_in are already synchronous to clk; lsclk is not.
module halt_wake_ctrl #(
    parameter int NUM_IRQ     = 4,
    parameter int KEY_W       = 4,
    parameter int TICK_DIV    = 1000,
    parameter int RST_TICKS   = 33,
    parameter int KEY_TICKS   = 65536,
    parameter int OSC_TIMEOUT = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_strobe,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               master_ie,
    input  logic               instr_done,
    input  logic               rst_pin,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               lsclk,
    input  logic               osc_chk_en,
    output logic               cpu_clk_en,
    output logic               wake_pulse,
    output logic               take_irq,
    output logic               sys_reset
);
    logic tick;
    logic pin_hit;
    logic key_hit;
    logic osc_stall;
    logic reset_req;

    hw_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    hw_hold_filter #(.THRESH(RST_TICKS)) u_pin_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (rst_pin),
        .hit   (pin_hit)
    );

    hw_hold_filter #(.THRESH(KEY_TICKS)) u_key_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (&key_in),
        .hit   (key_hit)
    );

    hw_osc_watch #(.TIMEOUT(OSC_TIMEOUT)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .lsclk   (lsclk),
        .stalled (osc_stall)
    );

    assign reset_req = pin_hit | key_hit | (osc_stall & osc_chk_en);

    // Register the merged reset request for a glitch-free output
    always_ff @(posedge clk) begin
        if (!rst_n) sys_reset <= 1'b0;
        else        sys_reset <= reset_req;
    end

    hw_halt_seq #(.NUM_IRQ(NUM_IRQ)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_strobe (halt_strobe),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .master_ie   (master_ie),
        .instr_done  (instr_done),
        .force_clr   (reset_req),
        .cpu_clk_en  (cpu_clk_en),
        .wake_pulse  (wake_pulse),
        .take_irq    (take_irq)
    );

    // R9: whenever sys_reset is seen the core is not parked
    p_reset_unparks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> cpu_clk_en);
    // R8: with the check disabled the oscillator cannot cause a reset alone
    p_osc_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_chk_en && !pin_hit && !key_hit) |=> !sys_reset);
endmodule

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
    localparam int NI   = 4;
    localparam int KW   = 4;
    localparam int DIV  = 4;
    localparam int RT   = 5;
    localparam int KT   = 6;
    localparam int OT   = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          halt_strobe;
    logic [NI-1:0] irq_req;
    logic [NI-1:0] irq_en;
    logic          master_ie;
    logic          instr_done;
    logic          rst_pin;
    logic [KW-1:0] key_in;
    logic          lsclk;
    logic          osc_chk_en;
    logic          cpu_clk_en;
    logic          wake_pulse;
    logic          take_irq;
    logic          sys_reset;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    halt_wake_ctrl #(
        .NUM_IRQ(NI), .KEY_W(KW), .TICK_DIV(DIV),
        .RST_TICKS(RT), .KEY_TICKS(KT), .OSC_TIMEOUT(OT)
    ) u_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe),
        .irq_req(irq_req), .irq_en(irq_en), .master_ie(master_ie),
        .instr_done(instr_done), .rst_pin(rst_pin), .key_in(key_in),
        .lsclk(lsclk), .osc_chk_en(osc_chk_en), .cpu_clk_en(cpu_clk_en),
        .wake_pulse(wake_pulse), .take_irq(take_irq), .sys_reset(sys_reset)
    );

    // Vector fields: [10:7] irq_req, [6:3] irq_en, [2] master_ie,
    // [1] expected wake, [0] expected interrupt entry
    localparam logic [10:0] VEC [7] = '{
        {4'b0001, 4'b0001, 1'b1, 1'b1, 1'b1},
        {4'b0010, 4'b0010, 1'b0, 1'b1, 1'b0},
        {4'b0100, 4'b0000, 1'b1, 1'b0, 1'b0},
        {4'b1000, 4'b0111, 1'b1, 1'b0, 1'b0},
        {4'b1010, 4'b1000, 1'b0, 1'b1, 1'b0},
        {4'b0000, 4'b1111, 1'b1, 1'b0, 1'b0},
        {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_halt();
        halt_strobe = 1'b1;
        nstep(1);
        halt_strobe = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; halt_strobe = 1'b0; irq_req = '0; irq_en = '0;
        master_ie = 1'b0; instr_done = 1'b0; rst_pin = 1'b0; key_in = '0;
        lsclk = 1'b0; osc_chk_en = 1'b0;
        nstep(3);
        // R1: reset values
        chk("R1", "cpu_clk_en in reset", cpu_clk_en, 1'b1);
        chk("R1", "wake_pulse in reset", wake_pulse, 1'b0);
        chk("R1", "take_irq in reset", take_irq, 1'b0);
        chk("R1", "sys_reset in reset", sys_reset, 1'b0);
        rst_n = 1'b1;
        nstep(2);
        chk("R1", "cpu_clk_en after reset", cpu_clk_en, 1'b1);

        // R2..R5: vector table walk
        for (int i = 0; i < 7; i++) begin
            logic [10:0] v;
            v = VEC[i];
            do_halt();
            chk("R2", "clock stopped by halt", cpu_clk_en, 1'b0);
            irq_req = v[10:7]; irq_en = v[6:3]; master_ie = v[2];
            nstep(1);
            chk("R3", "wake pulse (R4 master_ie ignored)", wake_pulse, v[1]);
            chk("R3", "clock enable after request", cpu_clk_en, v[1]);
            if (v[1]) begin
                irq_req = '0;
                nstep(1);
                chk("R3", "wake pulse single cycle", wake_pulse, 1'b0);
                chk("R5", "no entry before handshake", take_irq, 1'b0);
                instr_done = 1'b1;
                nstep(1);
                instr_done = 1'b0;
                chk("R5", "entry after one instruction", take_irq, v[0]);
                nstep(1);
                chk("R5", "entry pulse single cycle", take_irq, 1'b0);
            end else begin
                nstep(1);
                chk("R3", "disabled source keeps halt", cpu_clk_en, 1'b0);
                irq_req = 4'b0001; irq_en = 4'b0001; master_ie = 1'b0;
                nstep(1);
                irq_req = '0;
                instr_done = 1'b1;
                nstep(1);
                instr_done = 1'b0;
                nstep(1);
            end
            irq_en = '0; master_ie = 1'b0;
        end

        // R6: long-held reset pin, with restart on early release; halted first (R9)
        do_halt();
        rst_pin = 1'b1;
        nstep((RT - 1) * DIV - 1);
        chk("R6", "pin short hold no reset", sys_reset, 1'b0);
        rst_pin = 1'b0;
        nstep(2);
        rst_pin = 1'b1;
        nstep((RT - 1) * DIV - 1);
        chk("R6", "count restarted after release", sys_reset, 1'b0);
        chk("R6", "still halted while counting", cpu_clk_en, 1'b0);
        nstep(8);
        chk("R6", "pin long hold resets", sys_reset, 1'b1);
        chk("R9", "reset clears halt", cpu_clk_en, 1'b1);
        rst_pin = 1'b0;
        nstep(3);
        chk("R6", "reset released with pin", sys_reset, 1'b0);

        // R7: full key group hold
        key_in = '1;
        nstep((KT - 1) * DIV - 1);
        chk("R7", "keys short hold no reset", sys_reset, 1'b0);
        key_in = 4'b1011;
        nstep(40);
        chk("R7", "partial key group no reset", sys_reset, 1'b0);
        key_in = '1;
        nstep((KT - 1) * DIV - 1);
        chk("R7", "count restarted after key release", sys_reset, 1'b0);
        nstep(8);
        chk("R7", "keys long hold resets", sys_reset, 1'b1);
        key_in = '0;
        nstep(3);
        chk("R7", "reset released with keys", sys_reset, 1'b0);

        // R8: stopped oscillator, check disabled
        nstep(40);
        chk("R8", "stopped osc ignored when disabled", sys_reset, 1'b0);
        lsclk = 1'b1;
        nstep(3);
        osc_chk_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            lsclk = ~lsclk;
            nstep(3);
        end
        chk("R8", "running osc no reset", sys_reset, 1'b0);
        lsclk = 1'b0;
        nstep(3);
        lsclk = 1'b1;
        nstep(OT + 3);
        chk("R8", "stall one edge before limit", sys_reset, 1'b0);
        nstep(1);
        chk("R8", "stall detected at limit", sys_reset, 1'b1);
        lsclk = 1'b0;
        nstep(3);
        lsclk = 1'b1;
        nstep(6);
        chk("R8", "restart clears reset", sys_reset, 1'b0);

        // R9: wake-up and oscillator reset on the same edge
        lsclk = 1'b0;
        nstep(3);
        do_halt();
        lsclk = 1'b1;
        chk("R9", "halted before collision", cpu_clk_en, 1'b0);
        nstep(OT + 3);
        chk("R9", "no reset yet", sys_reset, 1'b0);
        irq_req = 4'b0001; irq_en = 4'b0001; master_ie = 1'b1;
        nstep(1);
        chk("R9", "reset wins collision", sys_reset, 1'b1);
        chk("R9", "no wake pulse under reset", wake_pulse, 1'b0);
        chk("R9", "clock enabled under reset", cpu_clk_en, 1'b1);
        nstep(1);
        chk("R9", "no wake pulse after collision", wake_pulse, 1'b0);
        chk("R9", "no entry after collision", take_irq, 1'b0);
        irq_req = '0; irq_en = '0; osc_chk_en = 1'b0;
        nstep(3);
        chk("R8", "reset gone when check disabled", sys_reset, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule